// File: doc/BRIEF.md
# Logic-embedded retention flip-flop

This block models a flip-flop whose first stage is a reconfigurable threshold gate with a state-retaining register, and whose second stage is an ordinary volatile register. On a store command the gate counts how many of its odd number of inputs (`N_IN`, 3 or 5) are asserted. It records a 1 only when a strict majority is high. Some of the inputs can be pinned by per-slot tie controls, so the same cell works as a majority, AND or OR gate. Tying a slot high turns it into an OR of the free operands, and tying it low turns it into an AND. The tie controls may change on any cycle.

The retention register belongs to an always-on domain and keeps its bit through any number of power losses. The output register is volatile. While `pwr_ok` is low, the output register and both outputs read 0. After power returns, a sense command copies the retained bit into the output register. `q_valid` rises only after the first sense of each powered interval. A control state machine with three states tracks this:
- `S_OFF`: power absent.
- `S_STALE`: powered, but the output register has not been reloaded.
- `S_LIVE`: the output is valid.

The transitions are:
- power loss: any state → `S_OFF`.
- power return without sense: `S_OFF` → `S_STALE`.
- sense (requested now or held over from the off period): `S_OFF`/`S_STALE` → `S_LIVE`.

Top module: `lerf_cell`

## Requirements
- R1: While `rst_n` is low, the retention register, the output register and the pending-sense flag clear. After reset, `q` = 0 and `q_valid` = 0. The `mode` codes are: 2'b00 standby, 2'b01 store, 2'b10 sense, 2'b11 reserved (acts as standby).
- R2: With all tie enables low, a store with `pwr_ok` high writes 1 when at least (`N_IN`+1)/2 of the `opnd` bits are 1, and writes 0 otherwise.
- R3: Tie slots are the top (`N_IN`-1)/2 bits of `opnd`, and slot j replaces `opnd[N_IN-(N_IN-1)/2+j]`. With every slot tied high, a store writes the OR of the free operands `opnd[(N_IN+1)/2-1:0]`.
- R4: With every slot tied low, a store writes the AND of the free operands.
- R5: Tie settings take effect on the store edge at which they are presented. Back-to-back stores with different ties each use their own setting.
- R6: A store changes only the retention register. `q` and `q_valid` keep their values at that edge.
- R7: A sense with `pwr_ok` high loads the retained bit into `q`, and sets `q_valid` at the same clock edge.
- R8: While `pwr_ok` is low, `q` and `q_valid` are 0 at once, with no clock edge needed. The retained bit survives any number and any length of power-off intervals.
- R9: A store presented while `pwr_ok` is low is dropped and leaves the retained bit unchanged.
- R10: A sense presented while `pwr_ok` is low is remembered. It executes at the first clock edge with `pwr_ok` high, and that edge sets `q` and `q_valid`.
- R11: After power returns with no sense done or pending, `q_valid` and `q` stay 0 until a sense occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply good for the volatile domain |
| mode | input | 2 | Command: 00 standby, 01 store, 10 sense, 11 standby |
| opnd | input | N_IN | Gate operands |
| tie_en | input | (N_IN-1)/2 | Per-slot tie enable for the top operand bits |
| tie_val | input | (N_IN-1)/2 | Per-slot tie level |
| q | output | 1 | Volatile output stage |
| q_valid | output | 1 | Output reloaded since the last power-up |

## Verification
The bench sweeps every operand pattern under untied, tied-high and tied-low slots. A gate with an off-by-one threshold, or with swapped tie levels, would produce the wrong AND/OR/majority bit.

It also repeats power cycles of differing lengths with stores and senses issued while power is off. A design that cleared the retention register on power loss, accepted an off-period store, or lost the held sense would show the wrong `q` after power returns. Another case stores back-to-back with different ties. A design that registered the ties a cycle late would then keep the stale function. A design that let `q_valid` rise on power return alone would fail the stale-interval checks.

// File: rtl/lerf_pkg.sv
package lerf_pkg;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'b00,
        MD_STORE = 2'b01,
        MD_SENSE = 2'b10,
        MD_RSVD  = 2'b11
    } lerf_mode_e;

    typedef enum logic [1:0] {
        S_OFF   = 2'b00,
        S_STALE = 2'b01,
        S_LIVE  = 2'b10
    } lerf_state_e;

endpackage

// File: rtl/lerf_thresh.sv
module lerf_thresh #(
    parameter int N_IN = 3,
    localparam int NTIE  = (N_IN - 1) / 2,
    localparam int NFREE = N_IN - NTIE,
    localparam int THR   = (N_IN + 1) / 2,
    localparam int CW    = $clog2(N_IN + 1)
) (
    input  logic [N_IN-1:0] opnd,
    input  logic [NTIE-1:0] tie_en,
    input  logic [NTIE-1:0] tie_val,
    output logic            vote
);
    logic [N_IN-1:0] eff;
    logic [CW-1:0]   ones;

    // free operands pass straight through
    genvar gi;
    generate
        for (gi = 0; gi < NFREE; gi++) begin : g_free
            assign eff[gi] = opnd[gi];
        end
        // tie slots override the top operand bits
        for (gi = 0; gi < NTIE; gi++) begin : g_tie
            assign eff[NFREE+gi] = tie_en[gi] ? tie_val[gi] : opnd[NFREE+gi];
        end
    endgenerate

    always_comb begin
        ones = '0;
        for (int k = 0; k < N_IN; k++) begin
            ones = ones + CW'(eff[k]);
        end
    end

    assign vote = (ones >= CW'(THR));

endmodule

// File: rtl/lerf_retain.sv
module lerf_retain (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic wr_en,
    input  logic wr_bit,
    output logic ret_q
);
    // always-on storage: written only while powered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q <= 1'b0;
        end else if (pwr_ok && wr_en) begin
            ret_q <= wr_bit;
        end
    end

    // R9
    ret_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> $stable(ret_q));

endmodule

// File: rtl/lerf_ctrl.sv
module lerf_ctrl
    import lerf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic [1:0] mode,
    input  logic       ret_q,
    output logic       store_en,
    output logic       slave_q,
    output logic       live
);
    lerf_mode_e  md;
    lerf_state_e state_q, state_d;
    logic        pend_q;
    logic        sense_req;
    logic        do_sense;

    assign md        = lerf_mode_e'(mode);
    assign sense_req = (md == MD_SENSE);
    assign store_en  = (md == MD_STORE);
    assign do_sense  = pwr_ok && (sense_req || pend_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (pwr_ok) state_d = do_sense ? S_LIVE : S_STALE;
            end
            S_STALE: begin
                if (!pwr_ok)      state_d = S_OFF;
                else if (do_sense) state_d = S_LIVE;
            end
            S_LIVE: begin
                if (!pwr_ok) state_d = S_OFF;
            end
            default: state_d = S_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // outputs: volatile stage and held sense request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slave_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (!pwr_ok) begin
            slave_q <= 1'b0;
            if (sense_req) pend_q <= 1'b1;
        end else if (do_sense) begin
            slave_q <= ret_q;
            pend_q  <= 1'b0;
        end
    end

    assign live = (state_q == S_LIVE);

    // R7
    sense_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && sense_req) |=> (slave_q == $past(ret_q)) && (state_q == S_LIVE));

    // R6
    store_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && store_en && !pend_q) |=> $stable(slave_q));

    // R10
    sense_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_ok && sense_req) |=> pend_q);

    // R11
    stale_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && !sense_req && !pend_q && state_q != S_LIVE) |=> (state_q == S_STALE));

endmodule

// File: rtl/lerf_cell.sv
module lerf_cell #(
    parameter int N_IN = 3,
    localparam int NTIE = (N_IN - 1) / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_ok,
    input  logic [1:0]      mode,
    input  logic [N_IN-1:0] opnd,
    input  logic [NTIE-1:0] tie_en,
    input  logic [NTIE-1:0] tie_val,
    output logic            q,
    output logic            q_valid
);
    logic vote, ret_q, store_en, slave_q, live;

    lerf_thresh #(.N_IN(N_IN)) u_gate (
        .opnd    (opnd),
        .tie_en  (tie_en),
        .tie_val (tie_val),
        .vote    (vote)
    );

    lerf_retain u_ret (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .wr_en  (store_en),
        .wr_bit (vote),
        .ret_q  (ret_q)
    );

    lerf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_ok   (pwr_ok),
        .mode     (mode),
        .ret_q    (ret_q),
        .store_en (store_en),
        .slave_q  (slave_q),
        .live     (live)
    );

    // volatile domain reads 0 while unpowered
    assign q       = pwr_ok & slave_q;
    assign q_valid = pwr_ok & live;

endmodule

// File: tb/test_lerf_cell.sv
module test_lerf_cell;
    localparam int N_IN = 3;
    localparam int NTIE = (N_IN - 1) / 2;
    localparam int NFREE = N_IN - NTIE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [N_IN-1:0] opnd = '0;
    logic [NTIE-1:0] tie_en = '0;
    logic [NTIE-1:0] tie_val = '0;
    logic q, q_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int m_ret = 0, m_slave = 0, m_valid = 0, m_pend = 0;

    always #10 clk = ~clk;

    lerf_cell #(.N_IN(N_IN)) i_lerf_cell (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .mode(mode),
        .opnd(opnd), .tie_en(tie_en), .tie_val(tie_val),
        .q(q), .q_valid(q_valid)
    );

    function automatic int ref_vote();
        int n = 0;
        for (int k = 0; k < N_IN; k++) begin
            if (k >= NFREE && tie_en[k-NFREE]) n += tie_val[k-NFREE];
            else                               n += opnd[k];
        end
        return (n >= (N_IN + 1) / 2) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: update reference at the edge, compare away from it
    task automatic step(input string tag);
        int old;
        @(posedge clk);
        if (!pwr_ok) begin
            m_slave = 0; m_valid = 0;
            if (mode == 2'b10) m_pend = 1;
        end else begin
            old = m_ret;
            if (mode == 2'b01) m_ret = ref_vote();
            if (mode == 2'b10 || m_pend == 1) begin
                m_slave = old; m_valid = 1; m_pend = 0;
            end
        end
        @(negedge clk);
        chk({tag, " q"}, int'(q), pwr_ok ? m_slave : 0);
        chk({tag, " q_valid"}, int'(q_valid), pwr_ok ? m_valid : 0);
    endtask

    task automatic store_sense(input string tag, input logic [N_IN-1:0] v);
        opnd = v; mode = 2'b01; step(tag);
        mode = 2'b10; step(tag);
        mode = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 q in reset", int'(q), 0);
        chk("R1 q_valid in reset", int'(q_valid), 0);
        rst_n = 1'b1;
        pwr_ok = 1'b1;
        mode = 2'b10; step("R1 sense after reset");
        chk("R1 retained 0 after reset", int'(q), 0);
        mode = 2'b00;

        // R2 majority, all patterns
        tie_en = '0;
        for (int v = 0; v < (1 << N_IN); v++) begin
            store_sense("R2", N_IN'(v));
            chk("R2 majority", int'(q), ($countones(N_IN'(v)) >= (N_IN + 1) / 2) ? 1 : 0);
        end
        // R3 ties high -> OR
        tie_en = '1; tie_val = '1;
        for (int v = 0; v < (1 << N_IN); v++) begin
            store_sense("R3", N_IN'(v));
            chk("R3 OR", int'(q), (|(N_IN'(v) & N_IN'((1 << NFREE) - 1))) ? 1 : 0);
        end
        // R4 ties low -> AND
        tie_val = '0;
        for (int v = 0; v < (1 << N_IN); v++) begin
            store_sense("R4", N_IN'(v));
            chk("R4 AND", int'(q), (&v[NFREE-1:0]) ? 1 : 0);
        end

        // R5 back-to-back stores with changing ties
        opnd = N_IN'(1);
        tie_en = '1; tie_val = '1; mode = 2'b01; step("R5");
        tie_val = '0; step("R5");
        mode = 2'b10; step("R5");
        chk("R5 last tie wins (AND)", int'(q), 0);
        tie_val = '1; mode = 2'b01; step("R5");
        mode = 2'b10; step("R5");
        chk("R5 retie to OR", int'(q), 1);

        // R6 store leaves output alone
        opnd = '0; mode = 2'b01; step("R6");
        chk("R6 q held after store", int'(q), 1);
        chk("R6 valid held", int'(q_valid), 1);
        mode = 2'b11; step("R6 reserved code");
        chk("R6 reserved keeps q", int'(q), 1);
        mode = 2'b10; step("R7");
        chk("R7 sense loads 0", int'(q), 0);

        // R8/R11 repeated power cycles with a stored 1
        opnd = N_IN'(1); mode = 2'b01; step("R8");
        mode = 2'b10; step("R8");
        for (int c = 1; c <= 6; c++) begin
            mode = 2'b00;
            pwr_ok = 1'b0; #1;
            chk("R8 q drops at once", int'(q), 0);
            chk("R8 valid drops at once", int'(q_valid), 0);
            for (int w = 0; w < c; w++) step("R8 off");
            pwr_ok = 1'b1;
            step("R11 stale");
            chk("R11 not valid before sense", int'(q_valid), 0);
            mode = 2'b10; step("R8 restore");
            chk("R8 retained across cycles", int'(q), 1);
        end

        // R9 store while off dropped
        mode = 2'b00; opnd = '0; tie_en = '0;
        pwr_ok = 1'b0; mode = 2'b01; step("R9"); step("R9");
        mode = 2'b00; pwr_ok = 1'b1; step("R9");
        mode = 2'b10; step("R9");
        chk("R9 off store ignored", int'(q), 1);

        // R10 sense while off held
        mode = 2'b00; pwr_ok = 1'b0; step("R10");
        mode = 2'b10; step("R10");
        mode = 2'b00; step("R10");
        pwr_ok = 1'b1; step("R10");
        chk("R10 held sense valid", int'(q_valid), 1);
        chk("R10 held sense data", int'(q), 1);

        // mixed random traffic against the reference
        for (int r = 0; r < 400; r++) begin
            pwr_ok  = ($urandom_range(0, 5) != 0);
            mode    = 2'($urandom_range(0, 3));
            opnd    = N_IN'($urandom);
            tie_en  = NTIE'($urandom);
            tie_val = NTIE'($urandom);
            step("R2 R8 R10 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule